// File: doc/BRIEF.md
# Division-free banked address mapper

This unit turns a word address into a place in a banked memory of `NBANKS` banks, each holding `2^LOCAL_BITS` words. It returns the bank that holds the word, the word's index inside that bank, and a flag for addresses beyond the end of the memory. The bank count is factored at elaboration time into a power of two `2^n` times an odd factor. Only the odd factor needs any arithmetic: a remainder by a constant.

The in-bank index comes straight from address bits. It is the address shifted right by `n` and cut to `LOCAL_BITS` bits. No quotient by the bank count is ever formed. Because the odd factor and `2^LOCAL_BITS` share no divisor, this pairing still gives every address in range its own bank and slot. Since the bank is a true remainder, strided streams spread over banks in the usual way.

A valid-qualified address goes in. The result leaves either in the same cycle or through one output register, which carries the valid bit along with the data.

Top module: `bank_addr_mapper`

## Requirements
- R1: For every valid address below `NBANKS*2^LOCAL_BITS`, `out_bank` equals the address modulo `NBANKS` and is always less than `NBANKS`.
- R2: With an odd bank count, `out_local` equals the low `LOCAL_BITS` address bits.
- R3: With a bank count `2^n*R`, where R is odd and greater than 1, `out_bank` equals the low `n` address bits plus `2^n` times ((address >> n) mod R).
- R4: For any bank count, `out_local` equals (address >> n) mod `2^LOCAL_BITS`, where `n` is the number of trailing zero bits of `NBANKS`.
- R5: With a power-of-two bank count, `out_bank` is the low `n` address bits and `out_local` is the next `LOCAL_BITS` bits.
- R6: `out_oob` is 1 exactly when a valid address is at or above `NBANKS*2^LOCAL_BITS`. In that case bank and local are don't-care. `out_oob` is never 1 while `out_valid` is 0.
- R7: Over the addresses 0 to `NBANKS*2^LOCAL_BITS-1`, each (bank, local) pair is produced exactly once.
- R8: With `OUT_REG=1`, outputs appear one clock after the input, and `out_valid` repeats the previous cycle's `in_valid`. Synchronous active-high `rst` clears `out_valid`.
- R9: Take a stride S and P = `NBANKS`/gcd(`NBANKS`,S). Any P consecutive elements of a stream with stride S land in pairwise distinct banks, and element P lands in the same bank as element 0.
- R10: While `in_valid` is 0, `out_valid` and `out_oob` are 0 (one cycle later when registered).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address qualifier |
| in_addr | input | ADDR_W | Word address |
| out_valid | output | 1 | Result qualifier |
| out_bank | output | clog2(NBANKS) | Bank number |
| out_local | output | LOCAL_BITS | Word index inside the bank |
| out_oob | output | 1 | Address beyond the memory |

## Verification
The bench builds three mappers with `LOCAL_BITS=3` and `ADDR_W=8`:
- six banks (n=1, odd factor 3), registered;
- five banks (purely odd), unregistered;
- four banks (pure power of two), registered.

With 8-bit addresses, every address from 0 to 255 can be applied. That covers each mapper's whole valid range, the first address past it, and a long out-of-range tail. It also lets the bench tally every (bank, local) pair for all three factorings. The six-bank build has both a shift part and a remainder part, so it exercises the stitched bank number and the stride spreading with a stride that shares a factor with the bank count.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  // number of trailing zero bits of a positive value
  function automatic int trail_zeros(input int v);
    int cnt;
    cnt = 0;
    if (v > 0) begin
      for (int i = 0; i < 31; i++) begin
        if (((v >> i) & 1) != 0) break;
        cnt++;
      end
    end
    return cnt;
  endfunction

  // odd factor of a positive value
  function automatic int odd_factor(input int v);
    return v >> trail_zeros(v);
  endfunction

endpackage

// File: rtl/bank_mod_reduce.sv
// Remainder of an unsigned value by a constant modulus, shift-subtract chain.
module bank_mod_reduce #(
  parameter int IN_W = 8,
  parameter int MOD  = 3,
  localparam int RW  = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic [IN_W-1:0] val,
  output logic [RW-1:0]   rem
);

  if (MOD <= 1) begin : g_trivial
    assign rem = '0;
  end else begin : g_chain
    localparam logic [RW:0] MODV = (RW+1)'(MOD);
    logic [RW-1:0] part [IN_W+1];
    assign part[0] = '0;
    for (genvar i = 0; i < IN_W; i++) begin : g_step
      logic [RW:0] sh;
      assign sh = {part[i], val[IN_W-1-i]};
      assign part[i+1] = (sh >= MODV) ? RW'(sh - MODV) : sh[RW-1:0];
    end
    assign rem = part[IN_W];
  end

endmodule

// File: rtl/bank_map_core.sv
// Combinational bank / local index / range computation.
module bank_map_core #(
  parameter int NBANKS     = 6,
  parameter int LOCAL_BITS = 3,
  parameter int ADDR_W     = 8,
  localparam int BANK_W    = $clog2(NBANKS)
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [BANK_W-1:0]     bank,
  output logic [LOCAL_BITS-1:0] local_idx,
  output logic                  oob
);

  localparam int N_TZ = bank_map_pkg::trail_zeros(NBANKS);
  localparam int ODD  = bank_map_pkg::odd_factor(NBANKS);
  localparam int HI_W = ADDR_W - N_TZ;
  localparam logic [63:0] LIMIT = 64'(NBANKS) << LOCAL_BITS;

  // in-bank index: shifted address bits, no quotient
  assign local_idx = addr[N_TZ +: LOCAL_BITS];
  assign oob = 64'(addr) >= LIMIT;

  if (ODD == 1) begin : g_pow2
    assign bank = addr[N_TZ-1:0];
  end else begin : g_mixed
    localparam int RW = $clog2(ODD);
    logic [RW-1:0] rem;
    bank_mod_reduce #(.IN_W(HI_W), .MOD(ODD)) u_red (
      .val (addr[ADDR_W-1:N_TZ]),
      .rem (rem)
    );
    if (N_TZ == 0) begin : g_odd
      assign bank = rem;
    end else begin : g_even
      assign bank = {rem, addr[N_TZ-1:0]};
    end
  end

endmodule

// File: rtl/bank_map_stage.sv
// Optional output register carrying the valid bit with the data.
module bank_map_stage #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        out_data  <= '0;
      end else begin
        out_valid <= in_valid;
        out_data  <= in_data;
      end
    end
  end else begin : g_pass
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper #(
  parameter int NBANKS     = 6,
  parameter int LOCAL_BITS = 3,
  parameter int ADDR_W     = 8,
  parameter bit OUT_REG    = 1'b1,
  localparam int BANK_W    = $clog2(NBANKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [ADDR_W-1:0]     in_addr,
  output logic                  out_valid,
  output logic [BANK_W-1:0]     out_bank,
  output logic [LOCAL_BITS-1:0] out_local,
  output logic                  out_oob
);

  localparam int PW = 1 + BANK_W + LOCAL_BITS;

  logic [BANK_W-1:0]     c_bank;
  logic [LOCAL_BITS-1:0] c_local;
  logic                  c_oob;
  logic [PW-1:0]         packed_in, packed_out;

  bank_map_core #(.NBANKS(NBANKS), .LOCAL_BITS(LOCAL_BITS), .ADDR_W(ADDR_W)) u_core (
    .addr      (in_addr),
    .bank      (c_bank),
    .local_idx (c_local),
    .oob       (c_oob)
  );

  assign packed_in = {c_oob & in_valid, c_bank, c_local};

  bank_map_stage #(.W(PW), .REG(OUT_REG)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (packed_in),
    .out_valid (out_valid),
    .out_data  (packed_out)
  );

  assign {out_oob, out_bank, out_local} = packed_out;

endmodule

// File: rtl/bank_addr_mapper_chk.sv
module bank_addr_mapper_chk #(
  parameter int NBANKS     = 6,
  parameter int LOCAL_BITS = 3,
  parameter int ADDR_W     = 8,
  parameter bit OUT_REG    = 1'b1,
  localparam int BANK_W    = $clog2(NBANKS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [ADDR_W-1:0]     in_addr,
  input logic                  out_valid,
  input logic [BANK_W-1:0]     out_bank,
  input logic [LOCAL_BITS-1:0] out_local,
  input logic                  out_oob
);

  localparam int N_TZ = bank_map_pkg::trail_zeros(NBANKS);
  localparam int ODD  = bank_map_pkg::odd_factor(NBANKS);
  localparam logic [63:0] LIMIT = 64'(NBANKS) << LOCAL_BITS;

  logic in_range;
  assign in_range = in_valid && (64'(in_addr) < LIMIT);

  // R1
  bank_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_oob) |-> (32'(out_bank) < NBANKS));

  // R6
  oob_qual_chk: assert property (@(posedge clk) disable iff (rst)
    out_oob |-> out_valid);

  if (OUT_REG) begin : g_seq
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_oob));
    // R4
    local_bits_chk: assert property (@(posedge clk) disable iff (rst)
      in_range |=> (out_local == $past(in_addr[N_TZ +: LOCAL_BITS])));
    if (ODD == 1) begin : g_p2
      // R5
      pow2_bank_chk: assert property (@(posedge clk) disable iff (rst)
        in_range |=> (out_bank == $past(in_addr[BANK_W-1:0])));
    end
  end else begin : g_comb
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> (!out_valid && !out_oob));
    // R4
    local_bits_chk: assert property (@(posedge clk) disable iff (rst)
      in_range |-> (out_local == in_addr[N_TZ +: LOCAL_BITS]));
  end

endmodule

bind bank_addr_mapper bank_addr_mapper_chk #(
  .NBANKS(NBANKS), .LOCAL_BITS(LOCAL_BITS), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
  .out_valid(out_valid), .out_bank(out_bank), .out_local(out_local), .out_oob(out_oob)
);

// File: tb/bank_addr_mapper_test.sv
`timescale 1ns/1ps
module bank_addr_mapper_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_addr = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  logic v6, o6, v5, o5, v4, o4;
  logic [2:0] b6, l6, b5, l5, l4;
  logic [1:0] b4;

  bank_addr_mapper #(.NBANKS(6), .LOCAL_BITS(3), .ADDR_W(8), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(v6), .out_bank(b6), .out_local(l6), .out_oob(o6));

  bank_addr_mapper #(.NBANKS(5), .LOCAL_BITS(3), .ADDR_W(8), .OUT_REG(1'b0)) uut_odd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(v5), .out_bank(b5), .out_local(l5), .out_oob(o5));

  bank_addr_mapper #(.NBANKS(4), .LOCAL_BITS(3), .ADDR_W(8), .OUT_REG(1'b1)) uut_p2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(v4), .out_bank(b4), .out_local(l4), .out_oob(o4));

  typedef struct packed {
    logic [7:0] a;
    logic [2:0] b;
    logic [2:0] l;
    logic       o;
  } vec_t;

  // six-bank build: address, bank, local, out-of-range
  localparam vec_t VEC [10] = '{
    '{8'd0,  3'd0, 3'd0, 1'b0},
    '{8'd1,  3'd1, 3'd0, 1'b0},
    '{8'd5,  3'd5, 3'd2, 1'b0},
    '{8'd6,  3'd0, 3'd3, 1'b0},
    '{8'd7,  3'd1, 3'd3, 1'b0},
    '{8'd11, 3'd5, 3'd5, 1'b0},
    '{8'd13, 3'd1, 3'd6, 1'b0},
    '{8'd30, 3'd0, 3'd7, 1'b0},
    '{8'd47, 3'd5, 3'd7, 1'b0},
    '{8'd48, 3'd0, 3'd0, 1'b1}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic apply(input logic v, input int a);
    in_valid = v;
    in_addr  = 8'(a);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int ref_local(input int a, input int n);
    return (a >> bank_map_pkg::trail_zeros(n)) % 8;
  endfunction

  int hit6 [6][8];
  int hit5 [5][8];
  int hit4 [4][8];

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    chk("R8 reset valid", int'(v6), 0);
    chk("R8 reset valid p2", int'(v4), 0);

    // table walk on the six-bank build
    foreach (VEC[i]) begin
      apply(1'b1, int'(VEC[i].a));
      chk("R6 table oob", int'(o6), int'(VEC[i].o));
      if (!VEC[i].o) begin
        chk("R3 table bank", int'(b6), int'(VEC[i].b));
        chk("R4 table local", int'(l6), int'(VEC[i].l));
      end
    end

    // exhaustive sweep over every address on all three builds
    for (int a = 0; a < 256; a++) begin
      apply(1'b1, a);
      chk("R8 valid", int'(v6), 1);
      chk("R6 oob6", int'(o6), int'(a >= 48));
      chk("R6 oob5", int'(o5), int'(a >= 40));
      chk("R6 oob4", int'(o4), int'(a >= 32));
      if (a < 48) begin
        chk("R1 bank6", int'(b6), a % 6);
        chk("R3 split6", int'(b6), (a % 2) + 2 * ((a >> 1) % 3));
        chk("R4 local6", int'(l6), ref_local(a, 6));
        if (int'(b6) < 6) hit6[b6][l6]++;
      end
      if (a < 40) begin
        chk("R1 bank5", int'(b5), a % 5);
        chk("R2 local5", int'(l5), a % 8);
        if (int'(b5) < 5) hit5[b5][l5]++;
      end
      if (a < 32) begin
        chk("R5 bank4", int'(b4), a % 4);
        chk("R5 local4", int'(l4), (a >> 2) % 8);
        hit4[b4][l4]++;
      end
    end

    // R7: each pair hit exactly once
    for (int b = 0; b < 6; b++) for (int l = 0; l < 8; l++) chk("R7 pairs6", hit6[b][l], 1);
    for (int b = 0; b < 5; b++) for (int l = 0; l < 8; l++) chk("R7 pairs5", hit5[b][l], 1);
    for (int b = 0; b < 4; b++) for (int l = 0; l < 8; l++) chk("R7 pairs4", hit4[b][l], 1);

    // R9: stride 4 on six banks gives runs of 3 distinct banks
    begin
      int bk [4];
      for (int i = 0; i < 4; i++) begin
        apply(1'b1, 3 + 4 * i);
        bk[i] = int'(b6);
      end
      chk("R9 distinct01", int'(bk[0] != bk[1]), 1);
      chk("R9 distinct02", int'(bk[0] != bk[2]), 1);
      chk("R9 distinct12", int'(bk[1] != bk[2]), 1);
      chk("R9 wrap", bk[3], bk[0]);
    end

    // R10: idle input, even with an out-of-range address present
    apply(1'b0, 200);
    chk("R10 idle valid", int'(v6), 0);
    chk("R10 idle oob", int'(o6), 0);
    chk("R10 idle oob odd", int'(o5), 0);

    // R8: one-cycle latency on the registered build
    in_valid = 1'b1;
    in_addr  = 8'd9;
    #1;
    chk("R8 not yet", int'(v6), 0);
    chk("R8 comb now", int'(v5), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R8 after edge", int'(v6), 1);
    chk("R8 bank after edge", int'(b6), 3);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 drop", int'(v6), 0);

    // R8: reset clears the valid output
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 reset clears", int'(v6), 0);
    rst = 1'b0;
    in_valid = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule